// File: doc/BRIEF.md
# Asynchronous Serial Port with Sticky Status Latches

This block is a byte-wide asynchronous serial port. The host places a byte in a transmit holding register. The port moves that byte into a shift register and sends it as a 10-bit frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. On the receive side the port watches the incoming line for a start bit, assembles eight data bits, checks the stop bit, and places the finished byte in a receive holding register. Three level interrupt outputs tell the host when a new byte may be written, when the last frame has left the line, and when a received byte is waiting.

The block does not generate its own bit clocks. A timer outside the block supplies a single-cycle transmit enable once per bit period (`tx_tick`). It also supplies a receive enable at `OVS` pulses per bit period (`rx_tick`), from which the receiver finds the middle of each bit. An 8-bit status word reports three sticky, active-low error latches: frame error, receive overrun, and an external keyboard-overrun event. It also reports a receive-busy flag. Any pulse on `stat_clr` returns the three latches to 1.

A two-bit control register has two mode bits. The tone bit makes the output line follow `tone_hi` while the current bit is 1 and `tone_lo` while it is 0. The break bit holds the output line low. The transmitter machine has four states: TX_IDLE, TX_START, TX_DATA and TX_STOP. On a tick, TX_IDLE goes to TX_START when the holding register is full, and the byte is loaded. TX_START goes to TX_DATA on the next tick. TX_DATA goes to TX_STOP after the eighth data bit. TX_STOP goes back to TX_START when another byte is waiting, and to TX_IDLE when none is. The receiver machine also has four states: RX_IDLE, RX_START, RX_DATA and RX_STOP. RX_IDLE goes to RX_START when a tick sees the line low. At the middle of the start bit, RX_START goes to RX_DATA if the line is still low, and back to RX_IDLE if it is high (a false start). RX_DATA goes to RX_STOP after the eighth data bit is sampled. RX_STOP goes to RX_IDLE once the stop bit is sampled, and at that point the byte is delivered.

Top module: `ser_port`

## Requirements
- R1: After reset, `tx_line` is 1, `status` is 8'hFD, `irq_need` is 1, `irq_done` is 1 and `irq_rdy` is 0.
- R2: A transmitted frame is a start bit of 0, then data bits 0 through 7 in that order, then a stop bit of 1. Each bit lasts from one `tx_tick` to the next, and the line is 1 when idle.
- R3: `irq_need` is 1 exactly when the transmit holding register is empty. It goes to 0 the cycle after `tx_wr`, and back to 1 when a `tx_tick` moves the byte into the shifter.
- R4: `irq_done` is 1 only while the holding register is empty and no frame is being sent.
- R5: The receiver samples each bit at the middle of its period, counting `OVS` ticks of `rx_tick` per bit. After the stop bit is sampled, the byte appears on `rx_rdata` and `irq_rdy` goes to 1. A pulse on `rx_rd` returns `irq_rdy` to 0.
- R6: A stop bit sampled as 0 clears `status[7]` (frame error, active low), and the bit stays 0 until cleared.
- R7: If a byte completes while `irq_rdy` is 1 and `rx_rd` is not asserted, `status[6]` (overrun, active low) clears and stays 0, and `rx_rdata` takes the newer byte.
- R8: A pulse on `kb_ovr` clears `status[5]` (keyboard overrun, active low), and the bit stays 0 until cleared.
- R9: A pulse on `stat_clr` sets `status[7:5]` back to 3'b111. If an error event arrives in the same cycle, the error wins.
- R10: `status[1]` is 1 from the detection of a start bit until the stop bit is sampled. Status bits 4, 3, 2 and 0 always read 1.
- R11: Writing the control register with bit 1 (break) set drives `tx_line` to 0 from the next cycle on, whatever the mode or frame.
- R12: With control bit 0 (tone) set and break clear, `tx_line` follows `tone_hi` while the current bit, including the idle level, is 1. It follows `tone_lo` while the current bit is 0.
- R13: A start bit that has gone high again by its midpoint sample is dropped. The receiver returns to idle and delivers no byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | DATA_W | Byte to send |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 2 | Bit 0 tone mode, bit 1 break |
| rx_rd | input | 1 | Read strobe; empties the receive holding register |
| stat_clr | input | 1 | Sets the three error latches back to 1 |
| kb_ovr | input | 1 | Keyboard-overrun event pulse |
| tx_tick | input | 1 | Transmit bit-period enable |
| rx_tick | input | 1 | Receive oversampling enable, OVS per bit |
| rx_line | input | 1 | Serial input line |
| tone_hi | input | 1 | Tone sent for 1 bits in tone mode |
| tone_lo | input | 1 | Tone sent for 0 bits in tone mode |
| tx_line | output | 1 | Serial output line |
| rx_rdata | output | DATA_W | Receive holding register |
| irq_need | output | 1 | Transmit holding register can accept a byte |
| irq_done | output | 1 | Transmission finished |
| irq_rdy | output | 1 | Received byte waiting |
| status | output | 8 | Status word |

## Verification
The assertions assume that `rst_n` is held long enough for every register to settle. They also assume that `kb_ovr` is never asserted together with `stat_clr` while a reception is in progress, since an error event would then rightly keep a latch cleared. The bench holds `rx_tick` high on every cycle and drives complete frames of `OVS` cycles per bit, with an idle gap between frames. It raises `stat_clr` and `rx_rd` only while the receiver is idle, so the clear and read properties always see a quiet receiver.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    // status word bit positions
    localparam int ST_FERR = 7;
    localparam int ST_OVR  = 6;
    localparam int ST_KOVR = 5;
    localparam int ST_BUSY = 1;

    // control word bit positions
    localparam int CTL_TONE = 0;
    localparam int CTL_BRK  = 1;

endpackage

// File: rtl/ser_tx.sv
module ser_tx
    import ser_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output logic              hold_full,
    output logic              active,
    output logic              bit_out
);

    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IW-1:0] LAST = IW'(DATA_W - 1);

    tx_state_t         st, st_n;
    logic              load;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] sh_q;
    logic [IW-1:0]     idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        load = 1'b0;
        unique case (st)
            TX_IDLE:  if (tick && hold_full) begin
                          st_n = TX_START;
                          load = 1'b1;
                      end
            TX_START: if (tick) st_n = TX_DATA;
            TX_DATA:  if (tick && idx_q == LAST) st_n = TX_STOP;
            TX_STOP:  if (tick) begin
                          if (hold_full) begin
                              st_n = TX_START;
                              load = 1'b1;
                          end else begin
                              st_n = TX_IDLE;
                          end
                      end
            default:  st_n = TX_IDLE;
        endcase
    end

    // holding register: a write in the load cycle wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (wr) begin
            hold_q    <= wdata;
            hold_full <= 1'b1;
        end else if (load) begin
            hold_full <= 1'b0;
        end
    end

    // shifter and bit index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= hold_q;
            idx_q <= '0;
        end else if (tick && st == TX_DATA) begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            TX_IDLE:  bit_out = 1'b1;
            TX_START: bit_out = 1'b0;
            TX_DATA:  bit_out = sh_q[0];
            TX_STOP:  bit_out = 1'b1;
            default:  bit_out = 1'b1;
        endcase
        active = (st != TX_IDLE);
    end

endmodule

// File: rtl/ser_rx.sv
module ser_rx
    import ser_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_in,
    output logic              done,
    output logic [DATA_W-1:0] byte_out,
    output logic              stop_bit,
    output logic              busy
);

    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] FULL = CW'(OVS - 1);
    localparam logic [IW-1:0] LAST = IW'(DATA_W - 1);

    rx_state_t         st, st_n;
    logic [1:0]        sync_q;
    logic              line_s;
    logic [CW-1:0]     cnt_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] sh_q;

    // two-flop synchronizer, idles high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_in};
    end
    assign line_s = sync_q[1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            RX_IDLE:  if (tick && !line_s) st_n = RX_START;
            RX_START: if (tick && cnt_q == MID) st_n = line_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && cnt_q == FULL && idx_q == LAST) st_n = RX_STOP;
            RX_STOP:  if (tick && cnt_q == FULL) st_n = RX_IDLE;
            default:  st_n = RX_IDLE;
        endcase
    end

    // tick counter, bit index, shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
        end else if (st_n != st) begin
            cnt_q <= '0;
            idx_q <= '0;
            if (st == RX_DATA) sh_q <= {line_s, sh_q[DATA_W-1:1]};
        end else if (tick) begin
            if (st == RX_DATA && cnt_q == FULL) begin
                cnt_q <= '0;
                idx_q <= idx_q + 1'b1;
                sh_q  <= {line_s, sh_q[DATA_W-1:1]};
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        done     = (st == RX_STOP) && tick && (cnt_q == FULL);
        stop_bit = line_s;
        byte_out = sh_q;
        busy     = (st != RX_IDLE);
    end

endmodule

// File: rtl/ser_stat.sv
module ser_stat
    import ser_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              stop_bit,
    input  logic              rd,
    input  logic              clr,
    input  logic              kb_evt,
    input  logic              busy,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic [7:0]        status
);

    logic ferr_n, ovr_n, kovr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
        end else if (rx_done) begin
            rx_data <= rx_byte;
            rx_full <= 1'b1;
        end else if (rd) begin
            rx_full <= 1'b0;
        end
    end

    // sticky active-low latches; a new error beats the clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ferr_n <= 1'b1;
            ovr_n  <= 1'b1;
            kovr_n <= 1'b1;
        end else begin
            if (rx_done && !stop_bit)      ferr_n <= 1'b0;
            else if (clr)                  ferr_n <= 1'b1;
            if (rx_done && rx_full && !rd) ovr_n  <= 1'b0;
            else if (clr)                  ovr_n  <= 1'b1;
            if (kb_evt)                    kovr_n <= 1'b0;
            else if (clr)                  kovr_n <= 1'b1;
        end
    end

    always_comb begin
        status          = 8'hFF;
        status[ST_FERR] = ferr_n;
        status[ST_OVR]  = ovr_n;
        status[ST_KOVR] = kovr_n;
        status[ST_BUSY] = busy;
    end

endmodule

// File: rtl/ser_port.sv
module ser_port
    import ser_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              ctl_wr,
    input  logic [1:0]        ctl_wdata,
    input  logic              rx_rd,
    input  logic              stat_clr,
    input  logic              kb_ovr,
    input  logic              tx_tick,
    input  logic              rx_tick,
    input  logic              rx_line,
    input  logic              tone_hi,
    input  logic              tone_lo,
    output logic              tx_line,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              irq_need,
    output logic              irq_done,
    output logic              irq_rdy,
    output logic [7:0]        status
);

    logic              tone_q, brk_q;
    logic              hold_full, tx_active, tx_bit;
    logic              rx_done, stop_bit, rx_busy, rx_full;
    logic [DATA_W-1:0] rx_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tone_q <= 1'b0;
            brk_q  <= 1'b0;
        end else if (ctl_wr) begin
            tone_q <= ctl_wdata[CTL_TONE];
            brk_q  <= ctl_wdata[CTL_BRK];
        end
    end

    ser_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (tx_wr),
        .wdata     (tx_wdata),
        .tick      (tx_tick),
        .hold_full (hold_full),
        .active    (tx_active),
        .bit_out   (tx_bit)
    );

    ser_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (rx_tick),
        .line_in  (rx_line),
        .done     (rx_done),
        .byte_out (rx_byte),
        .stop_bit (stop_bit),
        .busy     (rx_busy)
    );

    ser_stat #(.DATA_W(DATA_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_done  (rx_done),
        .rx_byte  (rx_byte),
        .stop_bit (stop_bit),
        .rd       (rx_rd),
        .clr      (stat_clr),
        .kb_evt   (kb_ovr),
        .busy     (rx_busy),
        .rx_data  (rx_rdata),
        .rx_full  (rx_full),
        .status   (status)
    );

    // line drive: break, then tone substitution, then plain bit
    always_comb begin
        if (brk_q)       tx_line = 1'b0;
        else if (tone_q) tx_line = tx_bit ? tone_hi : tone_lo;
        else             tx_line = tx_bit;
        irq_need = !hold_full;
        irq_done = !hold_full && !tx_active;
        irq_rdy  = rx_full;
    end

endmodule

// File: rtl/ser_port_chk.sv
module ser_port_chk
    import ser_port_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tx_wr,
    input logic       ctl_wr,
    input logic [1:0] ctl_wdata,
    input logic       rx_rd,
    input logic       stat_clr,
    input logic       kb_ovr,
    input logic       tx_line,
    input logic       irq_need,
    input logic       irq_done,
    input logic       irq_rdy,
    input logic [7:0] status
);

    AST_BRK_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[CTL_BRK]) |=> !tx_line); // R11

    AST_WR_FILLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !irq_need); // R3

    AST_DONE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> irq_need); // R4

    AST_RD_EMPTIES_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !status[ST_BUSY]) |=> !irq_rdy); // R5

    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[ST_FERR] && !stat_clr) |=> !status[ST_FERR]); // R6

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[ST_OVR] && !stat_clr) |=> !status[ST_OVR]); // R7

    AST_KOVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[ST_KOVR] && !stat_clr) |=> !status[ST_KOVR]); // R8

    AST_CLR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !status[ST_BUSY] && !kb_ovr) |=> (status[7:5] == 3'b111)); // R9

endmodule

bind ser_port ser_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_wr     (tx_wr),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .rx_rd     (rx_rd),
    .stat_clr  (stat_clr),
    .kb_ovr    (kb_ovr),
    .tx_line   (tx_line),
    .irq_need  (irq_need),
    .irq_done  (irq_done),
    .irq_rdy   (irq_rdy),
    .status    (status)
);

// File: tb/ser_port_bench.sv
`timescale 1ns/1ps
module ser_port_bench;

    localparam int OVS = 16;
    localparam int TXP = 8;   // cycles per transmit bit

    // {byte, stop bit driven}
    localparam logic [8:0] VEC [6] = '{
        {8'h55, 1'b1}, {8'hA3, 1'b1}, {8'h00, 1'b1},
        {8'hFF, 1'b1}, {8'h3C, 1'b0}, {8'h81, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_wr = 1'b0, ctl_wr = 1'b0, rx_rd = 1'b0, stat_clr = 1'b0, kb_ovr = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic [1:0] ctl_wdata = '0;
    logic       tx_tick = 1'b0, rx_tick = 1'b1, rx_line = 1'b1;
    logic       tone_hi = 1'b1, tone_lo = 1'b0;
    logic       tx_line, irq_need, irq_done, irq_rdy;
    logic [7:0] rx_rdata, status;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ser_port #(.DATA_W(8), .OVS(OVS)) u_ser_port (
        .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .rx_rd(rx_rd), .stat_clr(stat_clr),
        .kb_ovr(kb_ovr), .tx_tick(tx_tick), .rx_tick(rx_tick), .rx_line(rx_line),
        .tone_hi(tone_hi), .tone_lo(tone_lo), .tx_line(tx_line), .rx_rdata(rx_rdata),
        .irq_need(irq_need), .irq_done(irq_done), .irq_rdy(irq_rdy), .status(status)
    );

    // transmit bit-period enable
    initial begin
        int n = 0;
        forever begin
            @(posedge clk);
            #1;
            n++;
            tx_tick = (n % TXP == 0);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        cyc(1);
        s = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stopv);
        rx_line = 1'b0;
        cyc(OVS);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            cyc(OVS);
        end
        rx_line = stopv;
        cyc(OVS);
        rx_line = 1'b1;
        cyc(24);
    endtask

    task automatic cap_tx(output logic [7:0] b, output logic stopv);
        int n = 0;
        b = '0;
        @(negedge clk);
        while (tx_line !== 1'b0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        repeat (TXP/2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (TXP) @(negedge clk);
            b[i] = tx_line;
        end
        repeat (TXP) @(negedge clk);
        stopv = tx_line;
    endtask

    task automatic write_ctl(input logic [1:0] v);
        ctl_wdata = v;
        pulse(ctl_wr);
    endtask

    initial begin
        logic [7:0] got;
        logic       gstop;
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        @(negedge clk);
        chk("R1 tx_line", tx_line, 1);
        chk("R1 R10 status", status, 8'hFD);
        chk("R1 irq_need", irq_need, 1);
        chk("R1 irq_done", irq_done, 1);
        chk("R1 irq_rdy", irq_rdy, 0);

        // table walk: receive and transmit each vector byte
        for (int v = 0; v < 6; v++) begin
            cyc(1);
            send_rx(VEC[v][8:1], VEC[v][0]);
            @(negedge clk);
            chk("R5 rx_rdata", rx_rdata, VEC[v][8:1]);
            chk("R5 irq_rdy", irq_rdy, 1);
            chk("R6 frame latch", status[7], VEC[v][0]);
            chk("R10 idle busy", status[1], 0);
            cyc(1);
            pulse(rx_rd);
            pulse(stat_clr);
            @(negedge clk);
            chk("R5 rd clears", irq_rdy, 0);
            chk("R9 clr", status[7:5], 3'b111);

            cyc(1);
            tx_wdata = VEC[v][8:1];
            pulse(tx_wr);
            @(negedge clk);
            chk("R3 need low", irq_need, 0);
            chk("R4 done low", irq_done, 0);
            cap_tx(got, gstop);
            chk("R2 tx byte", got, VEC[v][8:1]);
            chk("R2 tx stop", gstop, 1);
            chk("R3 need back", irq_need, 1);
            repeat (TXP + 4) @(negedge clk);
            chk("R4 done back", irq_done, 1);
        end

        // busy during reception
        cyc(1);
        fork
            send_rx(8'h5A, 1'b1);
            begin
                cyc(40);
                @(negedge clk);
                chk("R10 busy", status[1], 1);
            end
        join
        cyc(1);
        pulse(rx_rd);

        // overrun: two frames without reading
        send_rx(8'h11, 1'b1);
        send_rx(8'h22, 1'b1);
        @(negedge clk);
        chk("R7 ovr latch", status[6], 0);
        chk("R7 newer byte", rx_rdata, 8'h22);
        cyc(30);
        @(negedge clk);
        chk("R7 ovr sticky", status[6], 0);
        cyc(1);
        pulse(rx_rd);
        pulse(stat_clr);
        @(negedge clk);
        chk("R9 ovr cleared", status[6], 1);

        // false start
        cyc(1);
        rx_line = 1'b0;
        cyc(3);
        rx_line = 1'b1;
        cyc(40);
        @(negedge clk);
        chk("R13 no byte", irq_rdy, 0);
        chk("R13 idle again", status, 8'hFD);

        // keyboard overrun latch
        cyc(1);
        pulse(kb_ovr);
        cyc(3);
        @(negedge clk);
        chk("R8 kovr latch", status[5], 0);
        cyc(1);
        pulse(stat_clr);
        @(negedge clk);
        chk("R9 kovr cleared", status[5], 1);

        // break
        cyc(1);
        write_ctl(2'b10);
        @(negedge clk);
        chk("R11 break low", tx_line, 0);
        cyc(1);
        write_ctl(2'b00);
        @(negedge clk);
        chk("R11 break off", tx_line, 1);

        // two-tone
        cyc(1);
        tone_hi = 1'b0;
        tone_lo = 1'b1;
        write_ctl(2'b01);
        @(negedge clk);
        chk("R12 idle uses tone_hi", tx_line, 0);
        cyc(1);
        tx_wdata = 8'h00;
        pulse(tx_wr);
        @(negedge clk);
        while (irq_need !== 1'b1) @(negedge clk);
        chk("R12 start uses tone_lo", tx_line, 1);
        tone_lo = 1'b0;
        @(negedge clk);
        chk("R12 follows tone_lo", tx_line, 0);
        cyc(12 * TXP);
        write_ctl(2'b00);
        tone_hi = 1'b1;
        @(negedge clk);
        chk("R12 mode off", tx_line, 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule